// File: doc/BRIEF.md
# Strobed Byte-Pair Word Assembler

This block runs on the host's system clock and rebuilds a 16-bit sample word, together with an over-range flag, from an 8-bit bus. The bus carries two bytes per word, and a single strobe frames them. The strobe is not related to the system clock. The block passes the strobe, the bus and the clip line through a synchronizer. It detects both strobe edges. On the rising edge it keeps the first byte in a holding register. On the falling edge it combines that byte with the second one.

A byte-order input selects which half of the word arrives first. The clip flag always travels with the high byte, so it is taken on whichever edge delivers that byte. The word, the clip bit and a one-cycle valid pulse all change on the same system clock cycle. A downstream consumer, such as a converter or a FIFO, therefore never sees a half-updated word.

A falling edge that arrives before any rising edge since reset has no first byte to pair with. Such an edge is dropped, and it sets a sticky framing-error flag.

Top module: `byte_pair_assembler`

## Requirements
- R1: On each detected rising strobe edge, the byte on the bus is stored as the first byte of the pair. It does not reach `word_o` until the matching falling edge.
- R2: On each detected falling edge that follows a rising edge, `word_o` takes the pair. If `hi_first_i` was 1 when the rising edge was acted on, the result is {first, second}. If it was 0, the result is {second, first}.
- R3: `clip_o` takes the value that `clip_i` had alongside the high byte. With `hi_first_i`=1 that is the value at the rising edge. With `hi_first_i`=0 it is the value at the falling edge. A value of 1 means over-range or under-range, and 0 means a normal result.
- R4: `word_o` and `clip_o` change only on a cycle in which `valid_o` is 1. They hold their values on every other cycle.
- R5: `valid_o` is a pulse exactly one cycle wide, issued once per accepted word.
- R6: A falling edge with no rising edge since reset raises `frame_err_o`. That edge leaves `word_o`, `clip_o` and `valid_o` unchanged. `frame_err_o` then stays at 1 until reset.
- R7: When `rst_n` is low at a clock edge, the next cycle shows `word_o`=0, `clip_o`=0, `valid_o`=0 and `frame_err_o`=0, and the pairing state is cleared.
- R8: The strobe, bus and clip pass through two synchronizer flops and one further delay flop. An edge is acted on at the third rising clock edge after the first clock edge that samples the new strobe level. The outputs show the result after that clock edge. The bus and clip are taken from the same synchronizer stage as the strobe, and the shortest strobe phase is one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_i | input | 1 | Asynchronous byte strobe: high frames the first byte, low frames the second byte |
| byte_i | input | 8 | Byte bus from the converter |
| clip_i | input | 1 | Over/under-range line, meaningful alongside the high byte |
| hi_first_i | input | 1 | 1: the high byte comes first; 0: the low byte comes first |
| word_o | output | 16 | Assembled word |
| clip_o | output | 1 | Latched clip flag for the word |
| valid_o | output | 1 | One-cycle pulse when the word and clip flag update |
| frame_err_o | output | 1 | Sticky flag for a falling strobe edge with no rising edge before it |

## Verification
The embedded properties check on every cycle that `valid_o` never lasts two cycles, and that the word and clip hold still between valid pulses. They also check that the error flag never drops outside reset, that an orphan falling edge produces no word, that a detected rising edge is never seen on two consecutive cycles, and that reset clears the outputs. Other behaviours can be shown only by the bench's scenarios: that the correct byte lands in each half for both orders, that the clip is taken from the edge carrying the high byte, and the exact three-edge latency from strobe sample to output. The scenarios include a reset released while the strobe is high, one-cycle strobe phases, and the byte order changing between pairs.

// File: rtl/bpa_pkg.sv
// Package bpa_pkg
// Shared types for the byte-pair word assembler.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package bpa_pkg;

    // Strobe event classification from the edge detector
    typedef enum logic [1:0] {
        EV_NONE = 2'b00,
        EV_RISE = 2'b01,
        EV_FALL = 2'b10
    } strobe_ev_t;

endpackage

// File: rtl/bpa_sync.sv
// Module bpa_sync
// Multi-flop synchronizer for a bundle of asynchronous inputs, plus one
// extra delay stage so that a caller can compare two adjacent samples.
// Assumes: the bundle is sampled as a whole (the strobe, bus and clip
// move together), so every bit sees the same latency. The flops carry
// no reset, so they track the inputs while the rest of the block is held.
module bpa_sync #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] q_dly_o
);
    localparam int CHAIN = STAGES + 1;

    logic [W-1:0] stg [CHAIN];

    // First stage: capture the raw asynchronous bundle
    always_ff @(posedge clk) begin
        stg[0] <= d_i;
    end

    genvar gi;
    generate
        for (gi = 1; gi < CHAIN; gi++) begin : g_chain
            // Shift one stage further along the chain
            always_ff @(posedge clk) begin
                stg[gi] <= stg[gi-1];
            end
        end
    endgenerate

    assign q_o     = stg[STAGES-1];
    assign q_dly_o = stg[STAGES];

endmodule

// File: rtl/bpa_edge.sv
// Module bpa_edge
// Classifies the synchronized strobe into rise / fall / none by comparing
// the synchronized level with its one-cycle-delayed copy.
// Assumes: both inputs come from adjacent stages of the same synchronizer.
module bpa_edge
    import bpa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_i,
    input  logic       lvl_dly_i,
    output strobe_ev_t ev_o
);
    // Combinational event decode from the level pair
    always_comb begin
        unique case ({lvl_i, lvl_dly_i})
            2'b10:   ev_o = EV_RISE;
            2'b01:   ev_o = EV_FALL;
            default: ev_o = EV_NONE;
        endcase
    end

    AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_o == EV_RISE) |=> (ev_o != EV_RISE)); // R8

    AST_FALL_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_o == EV_FALL) |=> (ev_o != EV_FALL)); // R8

endmodule

// File: rtl/bpa_frame.sv
// Module bpa_frame
// Pairs the bytes: keeps the first byte (and its order and clip
// information) on a rise, and on the following fall publishes the whole
// word and clip flag in one cycle with a single-cycle valid pulse.
// A fall with no rise since reset is dropped and sets a sticky error.
// Assumes: ev_i and the byte/clip inputs come from the same synchronizer
// stage; hi_first_i is steady around the rise that opens a pair.
module bpa_frame
    import bpa_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  strobe_ev_t          ev_i,
    input  logic [BYTE_W-1:0]   byte_i,
    input  logic                clip_i,
    input  logic                hi_first_i,
    output logic [2*BYTE_W-1:0] word_o,
    output logic                clip_o,
    output logic                valid_o,
    output logic                err_o
);
    localparam int WORD_W = 2 * BYTE_W;

    logic              armed_q;
    logic [BYTE_W-1:0] hold_byte_q;
    logic              hold_hi_q;
    logic              hold_clip_q;
    logic              take_word;
    logic              orphan_fall;
    logic [WORD_W-1:0] word_nxt;
    logic              clip_nxt;

    assign take_word   = (ev_i == EV_FALL) &&  armed_q;
    assign orphan_fall = (ev_i == EV_FALL) && !armed_q;

    // Place the held byte and the current byte in their halves
    always_comb begin
        if (hold_hi_q) begin
            word_nxt = {hold_byte_q, byte_i};
            clip_nxt = hold_clip_q;
        end else begin
            word_nxt = {byte_i, hold_byte_q};
            clip_nxt = clip_i;
        end
    end

    // Holding register: first byte, its order and its clip on a rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q     <= 1'b0;
            hold_byte_q <= '0;
            hold_hi_q   <= 1'b0;
            hold_clip_q <= 1'b0;
        end else if (ev_i == EV_RISE) begin
            armed_q     <= 1'b1;
            hold_byte_q <= byte_i;
            hold_hi_q   <= hi_first_i;
            if (hi_first_i) begin
                hold_clip_q <= clip_i;
            end
        end
    end

    // Output register: word and clip move together on an accepted fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
            clip_o <= 1'b0;
        end else if (take_word) begin
            word_o <= word_nxt;
            clip_o <= clip_nxt;
        end
    end

    // Valid pulse: one cycle per accepted word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
        end else begin
            valid_o <= take_word;
        end
    end

    // Sticky framing error for a fall with nothing to pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else if (orphan_fall) begin
            err_o <= 1'b1;
        end
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R5

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(word_o) && $stable(clip_o))); // R4

    AST_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(ev_i == EV_FALL)); // R2

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R6

    AST_ORPHAN_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        orphan_fall |=> (!valid_o && err_o)); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (word_o == '0 && !clip_o && !valid_o && !err_o)); // R7

endmodule

// File: rtl/byte_pair_assembler.sv
// Module byte_pair_assembler
// Top level: synchronizes the strobe/bus/clip bundle, finds strobe edges
// and assembles two bytes into one word with a latched clip flag.
// Assumes: strobe phases last at least one system clock and the bus is
// stable while the strobe is sampled at each level.
module byte_pair_assembler
    import bpa_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe_i,
    input  logic [BYTE_W-1:0]   byte_i,
    input  logic                clip_i,
    input  logic                hi_first_i,
    output logic [2*BYTE_W-1:0] word_o,
    output logic                clip_o,
    output logic                valid_o,
    output logic                frame_err_o
);
    localparam int BUNDLE_W = BYTE_W + 2;
    localparam int ST_BIT   = BUNDLE_W - 1;
    localparam int CL_BIT   = BUNDLE_W - 2;

    logic [BUNDLE_W-1:0] raw_bundle;
    logic [BUNDLE_W-1:0] sync_q;
    logic [BUNDLE_W-1:0] sync_dly;
    strobe_ev_t          ev;

    assign raw_bundle = {strobe_i, clip_i, byte_i};

    bpa_sync #(
        .W      (BUNDLE_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .d_i     (raw_bundle),
        .q_o     (sync_q),
        .q_dly_o (sync_dly)
    );

    bpa_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (sync_q[ST_BIT]),
        .lvl_dly_i (sync_dly[ST_BIT]),
        .ev_o      (ev)
    );

    bpa_frame #(
        .BYTE_W (BYTE_W)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev),
        .byte_i     (sync_q[BYTE_W-1:0]),
        .clip_i     (sync_q[CL_BIT]),
        .hi_first_i (hi_first_i),
        .word_o     (word_o),
        .clip_o     (clip_o),
        .valid_o    (valid_o),
        .err_o      (frame_err_o)
    );

endmodule

// File: tb/byte_pair_assembler_tb.sv
// Bench for byte_pair_assembler: behavioural reference built on a sample
// history queue, compared with the outputs on every falling clock edge.
module byte_pair_assembler_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe_i = 1'b0;
    logic [7:0]  byte_i = 8'h00;
    logic        clip_i = 1'b0;
    logic        hi_first_i = 1'b1;
    logic [15:0] word_o;
    logic        clip_o;
    logic        valid_o;
    logic        frame_err_o;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    // reference state
    logic [9:0]  hist[$];
    logic        m_armed, m_order, m_hold_clip, m_clip, m_valid, m_err;
    logic [7:0]  m_hold;
    logic [15:0] m_word;
    logic [9:0]  xa, xb;

    always #5 clk = ~clk;

    byte_pair_assembler u_dut (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .byte_i(byte_i),
        .clip_i(clip_i), .hi_first_i(hi_first_i), .word_o(word_o),
        .clip_o(clip_o), .valid_o(valid_o), .frame_err_o(frame_err_o)
    );

    initial begin
        hist = {10'h0, 10'h0, 10'h0};
        m_armed = 0; m_order = 0; m_hold_clip = 0; m_clip = 0;
        m_valid = 0; m_err = 0; m_hold = 0; m_word = 0;
    end

    // Reference: act on the samples taken two and three edges ago (R8)
    always @(posedge clk) begin
        xa = hist[hist.size()-2];
        xb = hist[hist.size()-3];
        m_valid = 1'b0;
        if (!rst_n) begin
            m_armed = 0; m_order = 0; m_hold_clip = 0; m_clip = 0;
            m_err = 0; m_hold = 0; m_word = 0;
        end else if (xa[9] && !xb[9]) begin
            m_armed = 1'b1;
            m_hold  = xa[7:0];
            m_order = hi_first_i;
            if (hi_first_i) m_hold_clip = xa[8];
        end else if (!xa[9] && xb[9]) begin
            if (!m_armed) begin
                m_err = 1'b1;
            end else begin
                m_word  = m_order ? {m_hold, xa[7:0]} : {xa[7:0], m_hold};
                m_clip  = m_order ? m_hold_clip : xa[8];
                m_valid = 1'b1;
            end
        end
        hist.push_back({strobe_i, clip_i, byte_i});
        if (hist.size() > 4) void'(hist.pop_front());
    end

    // Compare on every falling edge, away from the active edge
    always @(negedge clk) begin
        if (cycles > 2 && !done) begin
            vectors++;
            if (word_o !== m_word) begin
                fails++;
                $display("FAIL R1 R2 R4 word: actual %h expected %h (t=%0t)", word_o, m_word, $time);
            end
            if (clip_o !== m_clip) begin
                fails++;
                $display("FAIL R3 clip: actual %b expected %b (t=%0t)", clip_o, m_clip, $time);
            end
            if (valid_o !== m_valid) begin
                fails++;
                $display("FAIL R5 R8 valid: actual %b expected %b (t=%0t)", valid_o, m_valid, $time);
            end
            if (frame_err_o !== m_err) begin
                fails++;
                $display("FAIL R6 R7 frame_err: actual %b expected %b (t=%0t)", frame_err_o, m_err, $time);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++;
            $display("FAIL R5 watchdog: actual %0d cycles expected under 100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One pair: clip_i carries the true flag only next to the high byte (R3)
    task automatic send_pair(input logic [7:0] first, input logic [7:0] second,
                             input logic clp, input logic ord,
                             input int hi_cyc, input int lo_cyc);
        @(negedge clk);
        hi_first_i = ord;
        strobe_i   = 1'b1;
        byte_i     = first;
        clip_i     = ord ? clp : ~clp;
        idle(hi_cyc - 1);
        @(negedge clk);
        strobe_i = 1'b0;
        byte_i   = second;
        clip_i   = ord ? ~clp : clp;
        idle(lo_cyc - 1);
    endtask

    initial begin
        // R6: reset released with strobe already high, then an orphan fall
        strobe_i = 1'b1; byte_i = 8'h5A;
        idle(6);
        rst_n = 1'b1;
        idle(4);
        strobe_i = 1'b0; byte_i = 8'hC3;
        idle(6);
        send_pair(8'h12, 8'h34, 1'b1, 1'b1, 3, 4);
        idle(5);
        // R7: reset clears everything including the sticky error
        rst_n = 1'b0;
        idle(4);
        rst_n = 1'b1;
        idle(4);
        // R1 R2 R3: both orders, both clip values
        send_pair(8'hA1, 8'h5B, 1'b0, 1'b1, 4, 4);
        send_pair(8'hA1, 8'h5B, 1'b1, 1'b0, 4, 4);
        send_pair(8'hFF, 8'h00, 1'b1, 1'b1, 2, 3);
        send_pair(8'h00, 8'hFF, 1'b0, 1'b0, 3, 2);
        // R8: minimum one-cycle phases and order changing between pairs
        for (int k = 0; k < 40; k++) begin
            send_pair(8'(k * 37 + 5), 8'(k * 91 + 13), k[0], k[1] ^ k[2],
                      1 + (k % 3), 1 + ((k / 3) % 3));
        end
        // R4: long idle, outputs must hold
        idle(12);
        send_pair(8'h7E, 8'h81, 1'b1, 1'b0, 1, 1);
        idle(10);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule